// File: doc/BRIEF.md
# Cartridge Bank Mapper with Fetch-Triggered Pattern Latch

This block sits on a cartridge and turns two address buses into banked memory addresses. The CPU side is 16 bits wide. Its upper 32 KB window is split into four 8 KB program slots. Two of these slots follow software-written bank registers. The other two are pinned to the last two banks of the program ROM. Writes into that window are register writes. Through an index register and a data register they set the program banks, four pattern page values and the nametable mirroring mode.

The picture side is 14 bits wide. Its 8 KB pattern space is split into two 4 KB halves. Each half takes its page from one of two candidate registers. A single shared latch picks the candidate for both halves at once. The latch flips when the picture side fetches from either of two tile address ranges. The new state applies from the next picture-bus access, not the fetch that caused it. A page value of zero sends that half to pattern RAM instead of pattern ROM.

Top module: `fetch_latch_mapper`

## Requirements
- R1: After reset: program bank 0 = 0 and bank 1 = 1; pages A0 = A1 = 0 and B0 = B1 = 4; the latch is in state FD; `mirror_horiz_o` = 0.
- R2: A write is taken only when `cpu_addr_i[15]` = 1. It is decoded from address bits 15..13 and bit 0 only, so any alias in the same range acts like its base address. Writes below 0x8000 change nothing.
- R3: A write decoding to 0x8000 stores a 3-bit index taken from data bits 2:0. A write decoding to 0x8001 loads the register named by that index: 0 = A0, 1 = A1, 2 = B0, 4 = B1, 6 = program bank 0, 7 = program bank 1. Index values 3 and 5 change nothing.
- R4: A pattern page register stores its data byte with bits 1:0 cleared.
- R5: `prg_addr_o` = {bank, `cpu_addr_i[12:0]`}. The bank depends on `cpu_addr_i[14:13]`: slot 0 uses program bank 0, slot 1 uses program bank 1, slot 2 uses PRG_BANKS-2 and slot 3 uses PRG_BANKS-1. Bank numbers wrap modulo PRG_BANKS.
- R6: `ppu_addr_i[12]` selects the half: 0 uses A0 or A1, 1 uses B0 or B1. Latch state FD selects A0/B0 and FE selects A1/B1. `chr_addr_o` = {page[7:2], `ppu_addr_i[11:0]`}.
- R7: `chr_ram_sel_o` is 1 exactly when the selected page value is zero.
- R8: When `ppu_rd_i` = 1, the fetch address is ANDed with 0x1FF0. A result of 0x1FD0 sets the latch to FD and 0x1FE0 sets it to FE. Any other address, or `ppu_rd_i` = 0, leaves the latch unchanged. The mapping during the triggering fetch still uses the old latch state; the new state applies from the next cycle.
- R9: A write decoding to 0xA000 sets `mirror_horiz_o` to data bit 0 (1 = horizontal, 0 = vertical).
- R10: Writes decoding to 0xA001, 0xC000, 0xC001, 0xE000 or 0xE001 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_wr_i | input | 1 | CPU write strobe, sampled on the clock |
| ppu_addr_i | input | 14 | Picture-bus address |
| ppu_rd_i | input | 1 | Picture-bus fetch strobe, sampled on the clock |
| prg_addr_o | output | 13+clog2(PRG_BANKS) | Program ROM address |
| chr_addr_o | output | 18 | Pattern address (4 KB index, then offset) |
| chr_ram_sel_o | output | 1 | 1 = pattern RAM, 0 = pattern ROM |
| mirror_horiz_o | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The assertions check four things on every cycle. Writes below the register window leave the configuration unchanged, and so do writes to the inert decodes and the unused index values. The fixed slots always show the last two banks. A fetch from a trigger range moves the latch, and the latch holds when no fetch is made. The bench scenarios cover the rest:
- the actual address arithmetic: slot mapping, modulo wrap, page shift and clearing of the low bits;
- which page each latch state selects;
- that the mapping during the triggering fetch still uses the old state;
- redirection to pattern RAM for a zero page.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int unsigned CPU_AW  = 16;
  localparam int unsigned PPU_AW  = 14;
  localparam int unsigned DW      = 8;
  localparam int unsigned SLOT_OW = 13;  // 8 KB program slot offset
  localparam int unsigned HALF_OW = 12;  // 4 KB pattern half offset
  localparam int unsigned CHR_AW  = DW - 2 + HALF_OW;

  typedef enum logic [2:0] {
    IDX_A0 = 3'd0, IDX_A1 = 3'd1, IDX_B0 = 3'd2, IDX_B1 = 3'd4,
    IDX_P0 = 3'd6, IDX_P1 = 3'd7
  } reg_idx_e;

  // decoded {addr[14:13], addr[0]}
  typedef enum logic [2:0] {
    DEC_INDEX = 3'b000, DEC_DATA = 3'b001, DEC_MIRROR = 3'b010
  } dec_e;

  typedef struct packed {
    logic [2:0]    idx;
    logic [DW-1:0] prg0;
    logic [DW-1:0] prg1;
    logic [DW-1:0] pg_a0;
    logic [DW-1:0] pg_a1;
    logic [DW-1:0] pg_b0;
    logic [DW-1:0] pg_b1;
    logic          mir_h;
  } cfg_t;
endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic [DW-1:0]     cpu_data_i,
  input  logic              cpu_wr_i,
  output cfg_t              cfg_o
);
  cfg_t cfg_q, cfg_d;
  logic wr_en;
  logic [2:0] dec;
  logic [DW-1:0] pg_data;

  assign wr_en   = cpu_wr_i & cpu_addr_i[15];
  assign dec     = {cpu_addr_i[14:13], cpu_addr_i[0]};
  assign pg_data = {cpu_data_i[DW-1:2], 2'b00};

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      unique case (dec)
        DEC_INDEX:  cfg_d.idx   = cpu_data_i[2:0];
        DEC_MIRROR: cfg_d.mir_h = cpu_data_i[0];
        DEC_DATA: begin
          case (cfg_q.idx)
            IDX_A0:  cfg_d.pg_a0 = pg_data;
            IDX_A1:  cfg_d.pg_a1 = pg_data;
            IDX_B0:  cfg_d.pg_b0 = pg_data;
            IDX_B1:  cfg_d.pg_b1 = pg_data;
            IDX_P0:  cfg_d.prg0  = cpu_data_i;
            IDX_P1:  cfg_d.prg1  = cpu_data_i;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.idx   <= '0;
      cfg_q.prg0  <= DW'(0);
      cfg_q.prg1  <= DW'(1);
      cfg_q.pg_a0 <= DW'(0);
      cfg_q.pg_a1 <= DW'(0);
      cfg_q.pg_b0 <= DW'(4);
      cfg_q.pg_b1 <= DW'(4);
      cfg_q.mir_h <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  a_r2_low_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && !cpu_addr_i[15]) |=> $stable(cfg_q));

  a_r3_unused_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && dec == DEC_DATA && (cfg_q.idx == 3'd3 || cfg_q.idx == 3'd5))
    |=> $stable(cfg_q));

  a_r10_inert_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && cpu_addr_i[14:13] != 2'b00 && !(cpu_addr_i[14:13] == 2'b01 && !cpu_addr_i[0]))
    |=> $stable(cfg_q));
endmodule

// File: rtl/mapper_latch.sv
module mapper_latch
  import mapper_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PPU_AW-1:0] ppu_addr_i,
  input  logic              ppu_rd_i,
  output logic              sel_fe_o
);
  logic hit_fd, hit_fe, fe_q;

  assign hit_fd = (ppu_addr_i & PPU_AW'(14'h1FF0)) == PPU_AW'(14'h1FD0);
  assign hit_fe = (ppu_addr_i & PPU_AW'(14'h1FF0)) == PPU_AW'(14'h1FE0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                fe_q <= 1'b0;
    else if (ppu_rd_i && hit_fd) fe_q <= 1'b0;
    else if (ppu_rd_i && hit_fe) fe_q <= 1'b1;
  end

  assign sel_fe_o = fe_q;

  a_r8_set_fd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ppu_rd_i && ppu_addr_i[12:4] == 9'h1FD) |=> !sel_fe_o);

  a_r8_set_fe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ppu_rd_i && ppu_addr_i[12:4] == 9'h1FE) |=> sel_fe_o);

  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ppu_rd_i |=> $stable(sel_fe_o));
endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate
  import mapper_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 32,
  localparam int unsigned PRG_BW = $clog2(PRG_BANKS),
  localparam int unsigned PRG_AW = PRG_BW + SLOT_OW
) (
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic [PPU_AW-1:0] ppu_addr_i,
  input  logic [DW-1:0]     prg0_i,
  input  logic [DW-1:0]     prg1_i,
  input  logic [DW-1:0]     pg_a_i,
  input  logic [DW-1:0]     pg_b_i,
  output logic [PRG_AW-1:0] prg_addr_o,
  output logic [CHR_AW-1:0] chr_addr_o,
  output logic              chr_ram_sel_o
);
  logic [DW-1:0]     bank_raw;
  logic [PRG_BW-1:0] bank;
  logic [DW-1:0]     page;

  always_comb begin
    unique case (cpu_addr_i[14:13])
      2'd0: bank_raw = prg0_i;
      2'd1: bank_raw = prg1_i;
      2'd2: bank_raw = DW'(PRG_BANKS - 2);
      default: bank_raw = DW'(PRG_BANKS - 1);
    endcase
    bank = PRG_BW'(32'(bank_raw) % PRG_BANKS);
  end

  assign prg_addr_o    = {bank, cpu_addr_i[SLOT_OW-1:0]};
  assign page          = ppu_addr_i[HALF_OW] ? pg_b_i : pg_a_i;
  assign chr_addr_o    = {page[DW-1:2], ppu_addr_i[HALF_OW-1:0]};
  assign chr_ram_sel_o = (page == '0);
endmodule

// File: rtl/fetch_latch_mapper.sv
module fetch_latch_mapper
  import mapper_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 32,
  localparam int unsigned PRG_BW = $clog2(PRG_BANKS),
  localparam int unsigned PRG_AW = PRG_BW + SLOT_OW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_data_i,
  input  logic              cpu_wr_i,
  input  logic [13:0]       ppu_addr_i,
  input  logic              ppu_rd_i,
  output logic [PRG_AW-1:0] prg_addr_o,
  output logic [17:0]       chr_addr_o,
  output logic              chr_ram_sel_o,
  output logic              mirror_horiz_o
);
  cfg_t cfg;
  logic sel_fe;

  mapper_regs u_regs (
    .clk_i, .rst_ni, .cpu_addr_i, .cpu_data_i, .cpu_wr_i, .cfg_o(cfg)
  );

  mapper_latch u_latch (
    .clk_i, .rst_ni, .ppu_addr_i, .ppu_rd_i, .sel_fe_o(sel_fe)
  );

  mapper_xlate #(.PRG_BANKS(PRG_BANKS)) u_xlate (
    .cpu_addr_i, .ppu_addr_i,
    .prg0_i(cfg.prg0), .prg1_i(cfg.prg1),
    .pg_a_i(sel_fe ? cfg.pg_a1 : cfg.pg_a0),
    .pg_b_i(sel_fe ? cfg.pg_b1 : cfg.pg_b0),
    .prg_addr_o, .chr_addr_o, .chr_ram_sel_o
  );

  assign mirror_horiz_o = cfg.mir_h;

  a_r5_fixed_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[15:14] == 2'b11)
    |-> prg_addr_o[PRG_AW-1:SLOT_OW] == PRG_BW'(PRG_BANKS - 2 + 32'(cpu_addr_i[13])));
endmodule

// File: tb/fetch_latch_mapper_bench.sv
`timescale 1ns/1ps
module fetch_latch_mapper_bench;
  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_a = 0; logic [7:0] cpu_d = 0; logic cpu_w = 0;
  logic [13:0] ppu_a = 0; logic ppu_r = 0;
  logic [17:0] prg_o, chr_o; logic ram_o, mir_o;

  fetch_latch_mapper u_fetch_latch_mapper (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(cpu_a), .cpu_data_i(cpu_d), .cpu_wr_i(cpu_w),
    .ppu_addr_i(ppu_a), .ppu_rd_i(ppu_r), .prg_addr_o(prg_o), .chr_addr_o(chr_o),
    .chr_ram_sel_o(ram_o), .mirror_horiz_o(mir_o));

  always #2.5 clk = ~clk;

  typedef struct { int kind; int unsigned val; string tag; } item_t;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it; int unsigned act;
      it = q.pop_front();
      case (it.kind)
        0: act = 32'(prg_o);
        1: act = 32'(chr_o);
        2: act = 32'(ram_o);
        default: act = 32'(mir_o);
      endcase
      n_cmp++;
      if (act != it.val) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.val);
      end
    end
  end

  task automatic drive(input logic [15:0] a, input logic [7:0] d, input logic w,
                       input logic [13:0] p, input logic r);
    @(posedge clk); #1;
    cpu_a = a; cpu_d = d; cpu_w = w; ppu_a = p; ppu_r = r;
  endtask
  task automatic tick(); @(negedge clk); #0.5; endtask
  task automatic push(input int k, input int unsigned v, input string t);
    item_t it; it.kind = k; it.val = v; it.tag = t; q.push_back(it);
  endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    drive(a, d, 1, 0, 0); tick();
  endtask
  task automatic look(input logic [15:0] a, input logic [13:0] p); drive(a, 0, 0, p, 0); endtask
  task automatic fetch(input logic [13:0] p); drive(16'h0, 0, 0, p, 1); tick(); endtask

  initial begin
    #50000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R5 reset mapping
    look(16'h8000, 14'h0456); push(0, 32'h00000, "R1 slot0"); push(1, 32'h00456, "R1 A0");
    push(2, 1, "R1 R7 A0 zero ram"); push(3, 0, "R1 mirror"); tick();
    look(16'hA123, 14'h1456); push(0, 32'h02123, "R1 slot1"); push(1, 32'h01456, "R1 R6 B0");
    push(2, 0, "R1 B0 rom"); tick();
    look(16'hC005, 14'h0); push(0, 32'h3C005, "R5 slot2 fixed"); tick();
    look(16'hE010, 14'h0); push(0, 32'h3E010, "R5 slot3 fixed"); tick();
    // R3 / R5 program bank 0 with modulo wrap
    wr(16'h8000, 8'h06); wr(16'h8001, 8'h25);
    look(16'h8000, 14'h0); push(0, 32'h0A000, "R3 R5 prg0 wrap"); tick();
    look(16'h9FFF, 14'h0); push(0, 32'h0BFFF, "R5 slot0 offset"); tick();
    // R2 aliases
    wr(16'h9F02, 8'h07); wr(16'h9FFF, 8'h03);
    look(16'hA000, 14'h0); push(0, 32'h06000, "R2 alias prg1"); tick();
    // R4 pattern pages
    wr(16'h8000, 8'h00); wr(16'h8001, 8'h0B);
    look(16'h0, 14'h0010); push(1, 32'h02010, "R4 R6 A0"); push(2, 0, "R7 A0 rom"); tick();
    wr(16'h8000, 8'h02); wr(16'h8001, 8'h13);
    look(16'h0, 14'h1020); push(1, 32'h04020, "R6 B0"); tick();
    wr(16'h8000, 8'h01); wr(16'h8001, 8'h20);
    wr(16'h8000, 8'h04); wr(16'h8001, 8'h40);
    look(16'h0, 14'h0010); push(1, 32'h02010, "R6 FD keeps A0"); tick();
    // R8 latch
    fetch(14'h0FE8);
    look(16'h0, 14'h0010); push(1, 32'h02010, "R8 non-match"); tick();
    drive(16'h0, 0, 0, 14'h1FE4, 1); push(1, 32'h04FE4, "R8 old state during fetch"); tick();
    look(16'h0, 14'h1FE4); push(1, 32'h10FE4, "R8 R6 FE B1"); tick();
    look(16'h0, 14'h0010); push(1, 32'h08010, "R8 R6 FE A1"); tick();
    fetch(14'h1FC0);
    look(16'h0, 14'h0010); push(1, 32'h08010, "R8 other range"); tick();
    fetch(14'h3FD0);
    look(16'h0, 14'h0010); push(1, 32'h02010, "R8 bit13 masked FD"); tick();
    drive(16'h0, 0, 0, 14'h1FE0, 0); tick();
    look(16'h0, 14'h0010); push(1, 32'h02010, "R8 no strobe"); tick();
    // R3 unused index
    wr(16'h8000, 8'h03); wr(16'h8001, 8'hFF);
    wr(16'h8000, 8'h05); wr(16'h8001, 8'hFF);
    look(16'h8000, 14'h0010); push(0, 32'h0A000, "R3 idx3/5 prg0"); push(1, 32'h02010, "R3 idx3/5 A0"); tick();
    look(16'hA000, 14'h1020); push(0, 32'h06000, "R3 idx3/5 prg1"); push(1, 32'h04020, "R3 idx3/5 B0"); tick();
    // R9 / R10 mirroring
    wr(16'hA000, 8'h01);
    look(16'h0, 14'h0); push(3, 1, "R9 horizontal"); tick();
    wr(16'hA001, 8'h00); wr(16'hC000, 8'h00); wr(16'hE001, 8'h00); wr(16'hC001, 8'h00);
    look(16'h8000, 14'h0010); push(3, 1, "R10 inert mirror"); push(0, 32'h0A000, "R10 inert prg0"); tick();
    // R2 low writes
    wr(16'h0000, 8'h06); wr(16'h0001, 8'h00);
    look(16'h8000, 14'h0); push(0, 32'h0A000, "R2 low write ignored"); tick();
    wr(16'hBFFE, 8'h00);
    look(16'h0, 14'h0); push(3, 0, "R9 vertical"); tick();
    // R7 zero page in A1
    wr(16'h8000, 8'h01); wr(16'h8001, 8'h02);
    fetch(14'h1FE0);
    look(16'h0, 14'h0100); push(1, 32'h00100, "R7 R4 A1 zero addr"); push(2, 1, "R7 A1 ram"); tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule